// File: doc/BRIEF.md
# Hidden Configuration Register Unlock Decoder

This block watches an eight-offset drive register window on a simple synchronous I/O bus. It keeps a small bank of chip configuration registers out of sight behind the normal drive registers. An unlock sequence on the window opens the bank. The sequence is two back-to-back 16-bit reads of offset 1, then a byte write of 0x03 to offset 2. While the bank is open, five offsets reach the configuration registers instead of the drive. A byte write of 0x83 to offset 2 closes the bank again. All other traffic is forwarded to the drive through the `drv_rd` and `drv_wr` strobes, and the drive's read data is routed back to the bus.

The bank holds two timing sets, A and B. Each set has a read-cycle timing byte and a write-cycle timing byte. The bank also holds a control byte, a read-only strap byte and a miscellaneous byte. Bit 0 of the miscellaneous byte picks which set offsets 0 and 1 address. The upper bits of the miscellaneous byte form an address setup and ready-timing field that both drives share. When the control byte holds 0x85, drive 0 runs from set A and drive 1 runs from set B. The block drives the active timing bytes for the drive named on `drv_sel`, so that a downstream cycle-timing generator can use them.

The bus carries one access per cycle: `io_rd` and `io_wr` are never high together. Bus reads are combinational. Register writes and changes to the open/closed state take effect at the clock edge that ends the access.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the bank is closed. Both timing sets hold 0x5B in their read and write bytes. The control and miscellaneous bytes are 0, so `act_rd_tim` = `act_wr_tim` = 0x5B and `setup_out` = 0.
- R2: While the bank is closed, the bank opens after this sequence: two consecutive word reads of offset 1 (`io_word`=1), then a byte write (`io_word`=0) of 0x03 to offset 2. The opening write is not forwarded to the drive.
- R3: Any access that breaks the sequence clears the arming, and the sequence must then restart. Breaking accesses include a byte read of offset 1, an access to any other offset, a write to offset 2 of a value other than 0x03, and a single word read before the key. A key write that is not armed is forwarded to the drive and does not open the bank.
- R4: While the bank is closed, every read raises `drv_rd` with `io_rdata` = `drv_rdata`. Every write except the opening write raises `drv_wr`.
- R5: While the bank is open, offset 0 addresses the read timing byte and offset 1 the write timing byte of the set chosen by bit 0 of the miscellaneous byte (0 = set A, 1 = set B). Configuration reads return the byte in `io_rdata[7:0]` with the upper bits zero. Configuration accesses raise neither drive strobe.
- R6: While the bank is open, offset 5 reads the strap byte: bit 0 = `strap_clk25` (1 = 25 MHz, 0 = 33 MHz), all other bits 0. Writes to offset 5 change nothing.
- R7: While the bank is open, offset 3 reads and writes the control byte and offset 6 reads and writes the miscellaneous byte.
- R8: While the bank is open, a byte write of 0x83 to offset 2 closes the bank and is not forwarded. Afterwards offsets 0 to 7 reach the drive again.
- R9: While the bank is open, offsets 2, 4 and 7 still reach the drive, apart from the closing write. A write of any other value to offset 2 leaves the bank open.
- R10: `act_rd_tim` and `act_wr_tim` show set B when the control byte equals 0x85 and `drv_sel` = 1. Otherwise they show set A.
- R11: `setup_out` equals the miscellaneous byte with bit 0 forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 3 | Offset within the window |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_wdata | input | 16 | Write data (configuration writes use bits 7:0) |
| io_rdata | output | 16 | Read data back to the bus |
| drv_rdata | input | 16 | Read data from the drive registers |
| drv_rd | output | 1 | Read forwarded to the drive |
| drv_wr | output | 1 | Write forwarded to the drive |
| strap_clk25 | input | 1 | Bus clock strap, 1 = 25 MHz |
| drv_sel | input | 1 | Drive currently addressed |
| act_rd_tim | output | 8 | Active read-cycle timing byte |
| act_wr_tim | output | 8 | Active write-cycle timing byte |
| setup_out | output | 8 | Shared address setup and ready-timing field |

## Verification
Read data and the two drive strobes depend combinationally on the current access. The bench therefore samples them one nanosecond after it drives the access on the falling edge, within the same cycle. Register writes, opening and closing change state at the next rising edge. Timing outputs, setup output and the open state are checked only from the following falling edge onward. The open state is always checked through the ports, by whether the next read of offset 0 or offset 5 is forwarded.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam logic [2:0] OFS_TRD   = 3'd0;
  localparam logic [2:0] OFS_TWR   = 3'd1;
  localparam logic [2:0] OFS_KEY   = 3'd2;
  localparam logic [2:0] OFS_CTRL  = 3'd3;
  localparam logic [2:0] OFS_STRAP = 3'd5;
  localparam logic [2:0] OFS_MISC  = 3'd6;
  localparam logic [7:0] KEY_OPEN   = 8'h03;
  localparam logic [7:0] KEY_CLOSE  = 8'h83;
  localparam logic [7:0] CTRL_SPLIT = 8'h85;

  typedef struct packed {
    logic [7:0] rd;
    logic [7:0] wr;
  } tim_set_t;

  function automatic logic is_cfg_ofs(input logic [2:0] ofs);
    return (ofs == OFS_TRD) || (ofs == OFS_TWR) || (ofs == OFS_CTRL) ||
           (ofs == OFS_STRAP) || (ofs == OFS_MISC);
  endfunction

  function automatic logic use_set_b(input logic [7:0] ctrl, input logic sel);
    return (ctrl == CTRL_SPLIT) && sel;
  endfunction
endpackage

// File: rtl/cfgwin_unlock.sv
module cfgwin_unlock #(
  parameter int ARM_READS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_rd,
  input  logic       acc_wr,
  input  logic       acc_word,
  input  logic [2:0] acc_ofs,
  input  logic [7:0] acc_byte,
  output logic       bank_open,
  output logic       armed,
  output logic       key_hit,
  output logic       close_hit
);
  import cfgwin_pkg::*;
  localparam int CW = $clog2(ARM_READS + 1);
  localparam logic [CW-1:0] ARM_FULL = CW'(ARM_READS);

  logic [CW-1:0] arm_cnt;
  logic          arm_step;
  logic          byte_key_wr;

  assign armed       = (arm_cnt == ARM_FULL);
  assign arm_step    = acc_rd && acc_word && (acc_ofs == OFS_TWR);
  assign byte_key_wr = acc_wr && !acc_word && (acc_ofs == OFS_KEY);
  assign key_hit     = !bank_open && armed && byte_key_wr && (acc_byte == KEY_OPEN);
  assign close_hit   = bank_open && byte_key_wr && (acc_byte == KEY_CLOSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_open <= 1'b0;
      arm_cnt   <= '0;
    end else if (key_hit) begin
      bank_open <= 1'b1;
      arm_cnt   <= '0;
    end else if (close_hit) begin
      bank_open <= 1'b0;
      arm_cnt   <= '0;
    end else if (!bank_open && (acc_rd || acc_wr)) begin
      if (arm_step) arm_cnt <= armed ? arm_cnt : arm_cnt + 1'b1;
      else          arm_cnt <= '0;
    end
  end
endmodule

// File: rtl/cfgwin_regs.sv
module cfgwin_regs #(
  parameter logic [7:0] TIM_RESET = 8'h5B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [2:0] cfg_ofs,
  input  logic [7:0] cfg_wbyte,
  input  logic       strap_clk25,
  input  logic       drv_sel,
  output logic [7:0] cfg_rbyte,
  output logic [7:0] act_rd_tim,
  output logic [7:0] act_wr_tim,
  output logic [7:0] setup_out
);
  import cfgwin_pkg::*;
  localparam int NSETS = 2;

  tim_set_t   sets [NSETS];
  logic [7:0] ctrl_q;
  logic [7:0] misc_q;
  logic       idx;

  assign idx = misc_q[0];

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sets[g] <= '{rd: TIM_RESET, wr: TIM_RESET};
      end else if (cfg_wr && (idx == 1'(g))) begin
        if (cfg_ofs == OFS_TRD) sets[g].rd <= cfg_wbyte;
        if (cfg_ofs == OFS_TWR) sets[g].wr <= cfg_wbyte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      misc_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_ofs == OFS_CTRL) ctrl_q <= cfg_wbyte;
      if (cfg_ofs == OFS_MISC) misc_q <= cfg_wbyte;
    end
  end

  always_comb begin
    case (cfg_ofs)
      OFS_TRD:   cfg_rbyte = sets[idx].rd;
      OFS_TWR:   cfg_rbyte = sets[idx].wr;
      OFS_CTRL:  cfg_rbyte = ctrl_q;
      OFS_STRAP: cfg_rbyte = {7'b0, strap_clk25};
      OFS_MISC:  cfg_rbyte = misc_q;
      default:   cfg_rbyte = '0;
    endcase
  end

  logic act_b;
  assign act_b      = use_set_b(ctrl_q, drv_sel);
  assign act_rd_tim = act_b ? sets[1].rd : sets[0].rd;
  assign act_wr_tim = act_b ? sets[1].wr : sets[0].wr;
  assign setup_out  = {misc_q[7:1], 1'b0};
endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder #(
  parameter int         DATA_W    = 16,
  parameter int         ARM_READS = 2,
  parameter logic [7:0] TIM_RESET = 8'h5B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              io_word,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic [DATA_W-1:0] drv_rdata,
  output logic              drv_rd,
  output logic              drv_wr,
  input  logic              strap_clk25,
  input  logic              drv_sel,
  output logic [7:0]        act_rd_tim,
  output logic [7:0]        act_wr_tim,
  output logic [7:0]        setup_out
);
  import cfgwin_pkg::*;

  logic       bank_open, armed, key_hit, close_hit;
  logic       cfg_hit, cfg_wr;
  logic [7:0] cfg_rbyte;

  cfgwin_unlock #(.ARM_READS(ARM_READS)) u_unlock (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_rd    (io_rd),
    .acc_wr    (io_wr),
    .acc_word  (io_word),
    .acc_ofs   (io_addr),
    .acc_byte  (io_wdata[7:0]),
    .bank_open (bank_open),
    .armed     (armed),
    .key_hit   (key_hit),
    .close_hit (close_hit)
  );

  assign cfg_hit = bank_open && (io_rd || io_wr) && is_cfg_ofs(io_addr);
  assign cfg_wr  = cfg_hit && io_wr;

  cfgwin_regs #(.TIM_RESET(TIM_RESET)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_ofs     (io_addr),
    .cfg_wbyte   (io_wdata[7:0]),
    .strap_clk25 (strap_clk25),
    .drv_sel     (drv_sel),
    .cfg_rbyte   (cfg_rbyte),
    .act_rd_tim  (act_rd_tim),
    .act_wr_tim  (act_wr_tim),
    .setup_out   (setup_out)
  );

  assign drv_rd   = io_rd && !cfg_hit;
  assign drv_wr   = io_wr && !cfg_hit && !key_hit && !close_hit;
  assign io_rdata = cfg_hit ? {{(DATA_W-8){1'b0}}, cfg_rbyte} : drv_rdata;
endmodule

// File: rtl/cfgwin_checker.sv
module cfgwin_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  io_addr,
  input logic        io_rd,
  input logic        io_wr,
  input logic        io_word,
  input logic [15:0] io_wdata,
  input logic [15:0] io_rdata,
  input logic        drv_rd,
  input logic        drv_wr,
  input logic        strap_clk25,
  input logic        bank_open,
  input logic        armed,
  input logic        key_hit
);
  AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bank_open) |-> $past(armed && io_wr && !io_word && io_addr == 3'd2 &&
                               io_wdata[7:0] == 8'h03)); // R2
  AST_KEY_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |-> !drv_wr); // R2
  AST_CLOSED_READ_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_open && io_rd) |-> (drv_rd && io_rdata == 16'h0 || drv_rd)); // R4
  AST_CLOSE_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bank_open) |-> $past(io_wr && !io_word && io_addr == 3'd2 &&
                               io_wdata[7:0] == 8'h83)); // R8
  AST_CFG_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_open && (io_rd || io_wr) && (io_addr == 3'd0 || io_addr == 3'd6))
      |-> (!drv_rd && !drv_wr)); // R5
  AST_STRAP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_open && io_rd && io_addr == 3'd5) |-> (io_rdata == {15'b0, strap_clk25})); // R6
endmodule

bind cfgwin_decoder cfgwin_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_addr     (io_addr),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .io_word     (io_word),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .drv_rd      (drv_rd),
  .drv_wr      (drv_wr),
  .strap_clk25 (strap_clk25),
  .bank_open   (bank_open),
  .armed       (armed),
  .key_hit     (key_hit)
);

// File: tb/tb_cfgwin_decoder.sv
module tb_cfgwin_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0, io_word = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic [15:0] drv_rdata = 16'hA5C3;
  logic        drv_rd, drv_wr;
  logic        strap_clk25 = 1'b1;
  logic        drv_sel = 1'b0;
  logic [7:0]  act_rd_tim, act_wr_tim, setup_out;

  int checks = 0;
  int fails  = 0;
  logic [15:0] s_rd;
  logic        s_drd, s_dwr;

  always #5 clk = ~clk;

  cfgwin_decoder dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_word(io_word), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .drv_rdata(drv_rdata), .drv_rd(drv_rd), .drv_wr(drv_wr),
    .strap_clk25(strap_clk25), .drv_sel(drv_sel), .act_rd_tim(act_rd_tim),
    .act_wr_tim(act_wr_tim), .setup_out(setup_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus access: driven at the falling edge, sampled 1 ns later, state updates at the rising edge.
  task automatic acc(input logic rd, input logic word, input logic [2:0] ofs,
                     input logic [15:0] wd);
    @(negedge clk);
    io_rd = rd; io_wr = !rd; io_word = word; io_addr = ofs; io_wdata = wd;
    #1;
    s_rd = io_rdata; s_drd = drv_rd; s_dwr = drv_wr;
    @(posedge clk);
    #1;
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic do_unlock;
    acc(1, 1, 3'd1, 0);
    acc(1, 1, 3'd1, 0);
    acc(0, 0, 3'd2, 16'h0003);
  endtask

  // Bank state seen at the ports: a read of offset 0 is forwarded only when closed.
  task automatic expect_open(input string req, input logic exp_open);
    acc(1, 0, 3'd0, 0);
    check(req, {15'b0, !s_drd}, {15'b0, exp_open});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 act_rd", {8'b0, act_rd_tim}, 16'h005B);
    check("R1 act_wr", {8'b0, act_wr_tim}, 16'h005B);
    check("R1 setup", {8'b0, setup_out}, 16'h0000);
    acc(1, 0, 3'd0, 0);
    check("R1 closed R4 drv_rd", {15'b0, s_drd}, 16'h1);
    check("R4 rdata passthrough", s_rd, 16'hA5C3);
    acc(0, 1, 3'd6, 16'h1234);
    check("R4 write forwarded", {15'b0, s_dwr}, 16'h1);
  endtask

  task automatic t_breaks;
    acc(1, 1, 3'd1, 0); acc(1, 0, 3'd1, 0); acc(1, 1, 3'd1, 0);
    acc(0, 0, 3'd2, 16'h0003);
    check("R3 byte read breaks, key forwarded", {15'b0, s_dwr}, 16'h1);
    expect_open("R3 still closed after byte-read break", 1'b0);
    acc(1, 1, 3'd1, 0); acc(1, 1, 3'd1, 0); acc(0, 0, 3'd2, 16'h0004);
    acc(0, 0, 3'd2, 16'h0003);
    expect_open("R3 wrong key value breaks", 1'b0);
    acc(1, 1, 3'd1, 0); acc(1, 1, 3'd1, 0); acc(1, 1, 3'd0, 0);
    acc(0, 0, 3'd2, 16'h0003);
    expect_open("R3 other offset breaks", 1'b0);
    acc(1, 1, 3'd1, 0); acc(0, 0, 3'd2, 16'h0003);
    expect_open("R3 single word read not enough", 1'b0);
  endtask

  task automatic t_unlock;
    do_unlock();
    check("R2 key not forwarded", {15'b0, s_dwr}, 16'h0);
    acc(1, 0, 3'd5, 0);
    check("R2 open, strap not forwarded", {15'b0, s_drd}, 16'h0);
    check("R6 strap 25MHz", s_rd, 16'h0001);
    strap_clk25 = 1'b0;
    acc(0, 0, 3'd5, 16'h00FF);
    acc(1, 0, 3'd5, 0);
    check("R6 strap 33MHz, write ignored", s_rd, 16'h0000);
    strap_clk25 = 1'b1;
  endtask

  task automatic t_config;
    acc(0, 0, 3'd0, 16'h0032); acc(0, 0, 3'd1, 16'h0021);
    check("R5 cfg write not forwarded", {15'b0, s_dwr}, 16'h0);
    acc(0, 0, 3'd6, 16'h0001);
    acc(0, 0, 3'd0, 16'h0045); acc(0, 0, 3'd1, 16'h0034);
    acc(1, 1, 3'd0, 0);
    check("R5 set B read byte", s_rd, 16'h0045);
    acc(0, 0, 3'd6, 16'h0020);
    acc(1, 0, 3'd0, 0);
    check("R5 set A read byte", s_rd, 16'h0032);
    acc(1, 0, 3'd1, 0);
    check("R5 set A write byte", s_rd, 16'h0021);
    acc(1, 0, 3'd6, 0);
    check("R7 misc readback", s_rd, 16'h0020);
    check("R11 setup field", {8'b0, setup_out}, 16'h0020);
    drv_sel = 1'b1; #1;
    check("R10 unsplit drive1 uses A", {act_rd_tim, act_wr_tim}, 16'h3221);
    acc(0, 0, 3'd3, 16'h0085);
    acc(1, 0, 3'd3, 0);
    check("R7 ctrl readback", s_rd, 16'h0085);
    check("R10 split drive1 uses B", {act_rd_tim, act_wr_tim}, 16'h4534);
    drv_sel = 1'b0; #1;
    check("R10 split drive0 uses A", {act_rd_tim, act_wr_tim}, 16'h3221);
    acc(0, 0, 3'd6, 16'h0011);
    check("R11 bit0 cleared", {8'b0, setup_out}, 16'h0010);
  endtask

  task automatic t_pass_open;
    acc(1, 1, 3'd4, 0);
    check("R9 offset4 forwarded", {15'b0, s_drd}, 16'h1);
    check("R9 offset4 data", s_rd, 16'hA5C3);
    acc(0, 0, 3'd2, 16'h0010);
    check("R9 offset2 write forwarded", {15'b0, s_dwr}, 16'h1);
    expect_open("R9 bank stays open", 1'b1);
  endtask

  task automatic t_close;
    acc(0, 0, 3'd2, 16'h0083);
    check("R8 close not forwarded", {15'b0, s_dwr}, 16'h0);
    expect_open("R8 bank closed", 1'b0);
    acc(1, 0, 3'd6, 0);
    check("R8 offset6 back to drive", s_rd, 16'hA5C3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_breaks();
    t_unlock();
    t_config();
    t_pass_open();
    t_close();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule